// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This block is a register-mapped watchdog built around a free-running up-counter and a single compare value. Software clears the counter, programs the compare value and the actions to take on a match, then enables counting. When the counter reaches the compare value, the block can raise an interrupt, freeze the counter, change an external match pin, and launch a chip reset pulse. The reset pulse has a programmable width and comes in two flavours: internal only, or internal plus external. Software can also force either reset flavour at once.

Clearing the counter is not instantaneous. After a clear request, the counter reaches zero a fixed number of cycles later, so software polls the counter register until it reads zero. Counting can optionally pause while a debugger halts the system. A sticky status flag records that the watchdog issued a reset. Only the block's own power-on reset input clears that flag, so it survives the reset pulse it records.

The register port is a simple synchronous read/write bus with a word index. The byte offset is four times that index. Read data is registered and appears one cycle after the read strobe.

Top module: `wdog_match_timer`

## Requirements
- R1: After `rst`, all eight registers read 0 and `wdt_irq`, `match_out`, `sysrst_int` and `sysrst_ext` are low.
- R2: Control register (index 1) bit 0 enables counting, one step per cycle. Writing 0 to the control register stops the counter. The counter register (index 2) reads the live count.
- R3: Control bit 1 requests a counter clear. While it is set the counter does not count, and it reads 0 from the third cycle after the write. A read in the cycle right after the write still returns the old value.
- R4: With control bit 2 set, the counter holds while `dbg_halt` is high. With bit 2 clear, `dbg_halt` has no effect.
- R5: A match event fires once each time the counter equals the compare value (index 4) while counting is active. If match-config (index 3) bit 0 is set, the event sets interrupt flag bit 0 of index 0, which drives `wdt_irq`. Writing 1 to that bit clears it. When a clear and an event fall in the same cycle, the event wins.
- R6: With match-config bit 2 set, the counter stops at the compare value.
- R7: Pin-control register (index 5) bit 0 drives `match_out`. Its bits 5:4 pick the action on a match: 0 none, 1 drive low, 2 drive high, 3 toggle. A match action takes priority over a software write of bit 0 in the same cycle.
- R8: On a match, match-config bit 3 starts an internal reset pulse and bit 4 starts an internal-plus-external pulse. `sysrst_int` stays high for (pulse-length register, index 6, 16 bits) + 6 cycles. `sysrst_ext` only ever rises together with `sysrst_int`. A pulse in progress cannot be restarted.
- R9: Writing match-config bit 5 forces an internal pulse at once, and bit 6 forces an internal-plus-external pulse. Both bits read back as 0. A force that arrives while a pulse is running is ignored.
- R10: Reset-status register (index 7) bit 0 becomes 1 when a watchdog pulse starts. Bus writes do not clear it; only `rst` does.
- R11: Unused register bits read 0, and writes to the counter register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the count clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| dbg_halt | input | 1 | Debugger halt indication |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| wdt_irq | output | 1 | Match interrupt flag |
| match_out | output | 1 | External match pin |
| sysrst_int | output | 1 | Internal reset pulse |
| sysrst_ext | output | 1 | External reset pulse |

## Verification
The collision that matters most is a software write-1-to-clear of the interrupt flag landing in the same cycle as a new match event. The bench sets this up by clearing the counter, enabling it, and issuing the clear write exactly compare-value cycles later, so that it reaches the flag on the event edge. It then requires the flag to remain set. A second collision is a forced reset arriving while a pulse is already running. The bench judges this by measuring the total pulse width and the external output, which must match a single unrestarted internal pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_IRQ   = 3'd0,
    RG_CTRL  = 3'd1,
    RG_COUNT = 3'd2,
    RG_MCFG  = 3'd3,
    RG_MATCH = 3'd4,
    RG_PIN   = 3'd5,
    RG_PLEN  = 3'd6,
    RG_RSTAT = 3'd7
  } wdt_reg_e;

  typedef enum logic [1:0] {
    PA_NONE = 2'd0,
    PA_LOW  = 2'd1,
    PA_HIGH = 2'd2,
    PA_FLIP = 2'd3
  } pin_act_e;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int DW      = 32,
  parameter int CLR_LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clr_req,
  input  logic          freeze,
  input  logic          dbg_halt,
  input  logic          stop_on_match,
  input  logic [DW-1:0] match_val,
  output logic [DW-1:0] cnt,
  output logic          match_evt
);
  localparam int TW = $clog2(CLR_LAT + 1);

  logic [TW-1:0] clr_tmr;
  logic          clr_fire, active, hit, run, seen;

  // clear completes CLR_LAT cycles after the request appears
  always_ff @(posedge clk) begin
    if (rst || !clr_req) clr_tmr <= '0;
    else if (clr_tmr != TW'(CLR_LAT)) clr_tmr <= clr_tmr + TW'(1);
  end

  always_comb begin
    clr_fire  = clr_req && (clr_tmr == TW'(CLR_LAT - 1));
    active    = en && !clr_req && !(freeze && dbg_halt);
    hit       = (cnt == match_val);
    match_evt = active && hit && !seen;
    run       = active && !(stop_on_match && hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else begin
      if (clr_fire) cnt <= '0;
      else if (run) cnt <= cnt + DW'(1);
      seen <= hit && (seen || match_evt);
    end
  end
endmodule

// File: rtl/wdt_rstpulse.sv
module wdt_rstpulse #(
  parameter int PLS_W       = 16,
  parameter int PULSE_EXTRA = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             match_evt,
  input  logic             sel_int,
  input  logic             sel_ext,
  input  logic             force_int,
  input  logic             force_ext,
  input  logic [PLS_W-1:0] plen,
  output logic             fire,
  output logic             out_int,
  output logic             out_ext
);
  localparam int RW = PLS_W + 1;

  logic [RW-1:0] remain;
  logic          ext_q, forced, want_ext, req;

  always_comb begin
    forced   = force_int || force_ext;
    req      = forced || (match_evt && (sel_int || sel_ext));
    want_ext = forced ? force_ext : sel_ext;
    fire     = req && (remain == '0);
    out_int  = (remain != '0);
    out_ext  = out_int && ext_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      ext_q  <= 1'b0;
    end else if (fire) begin
      remain <= RW'(plen) + RW'(PULSE_EXTRA);
      ext_q  <= want_ext;
    end else if (remain != '0) begin
      remain <= remain - RW'(1);
    end
  end
endmodule

// File: rtl/wdog_match_timer.sv
module wdog_match_timer
  import wdt_pkg::*;
#(
  parameter int DW          = 32,
  parameter int PLS_W       = 16,
  parameter int PULSE_EXTRA = 6,
  parameter int CLR_LAT     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dbg_halt,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [REG_IDX_W-1:0] bus_word,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 wdt_irq,
  output logic                 match_out,
  output logic                 sysrst_int,
  output logic                 sysrst_ext
);
  logic             ctrl_en, ctrl_clr, ctrl_frz;
  logic             mc_irq, mc_stop, mc_rint, mc_rext;
  logic [DW-1:0]    match_q, cnt, rd_mux;
  pin_act_e         pmode;
  logic             pin_q, irq_q, sticky_q;
  logic [PLS_W-1:0] plen_q;
  logic             match_evt, pulse_fire;
  logic             wr_irq, wr_ctrl, wr_mcfg, wr_match, wr_pin, wr_plen;
  logic             force_int, force_ext;

  always_comb begin
    wr_irq    = bus_wr && (bus_word == RG_IRQ);
    wr_ctrl   = bus_wr && (bus_word == RG_CTRL);
    wr_mcfg   = bus_wr && (bus_word == RG_MCFG);
    wr_match  = bus_wr && (bus_word == RG_MATCH);
    wr_pin    = bus_wr && (bus_word == RG_PIN);
    wr_plen   = bus_wr && (bus_word == RG_PLEN);
    force_int = wr_mcfg && bus_wdata[5];
    force_ext = wr_mcfg && bus_wdata[6];
  end

  wdt_counter #(.DW(DW), .CLR_LAT(CLR_LAT)) u_cnt (
    .clk(clk), .rst(rst), .en(ctrl_en), .clr_req(ctrl_clr), .freeze(ctrl_frz),
    .dbg_halt(dbg_halt), .stop_on_match(mc_stop), .match_val(match_q),
    .cnt(cnt), .match_evt(match_evt)
  );

  wdt_rstpulse #(.PLS_W(PLS_W), .PULSE_EXTRA(PULSE_EXTRA)) u_pulse (
    .clk(clk), .rst(rst), .match_evt(match_evt), .sel_int(mc_rint),
    .sel_ext(mc_rext), .force_int(force_int), .force_ext(force_ext),
    .plen(plen_q), .fire(pulse_fire), .out_int(sysrst_int), .out_ext(sysrst_ext)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      {ctrl_frz, ctrl_clr, ctrl_en}       <= '0;
      {mc_rext, mc_rint, mc_stop, mc_irq} <= '0;
      match_q <= '0;
      pmode   <= PA_NONE;
      plen_q  <= '0;
    end else begin
      if (wr_ctrl) {ctrl_frz, ctrl_clr, ctrl_en} <= bus_wdata[2:0];
      if (wr_mcfg) {mc_rext, mc_rint, mc_stop, mc_irq} <=
                     {bus_wdata[4], bus_wdata[3], bus_wdata[2], bus_wdata[0]};
      if (wr_match) match_q <= bus_wdata;
      if (wr_pin)   pmode   <= pin_act_e'(bus_wdata[5:4]);
      if (wr_plen)  plen_q  <= bus_wdata[PLS_W-1:0];
    end
  end

  // status flags: hardware events win over software writes
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q    <= 1'b0;
      pin_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      if (match_evt && mc_irq)            irq_q <= 1'b1;
      else if (wr_irq && bus_wdata[0])    irq_q <= 1'b0;

      if (match_evt && pmode != PA_NONE) begin
        case (pmode)
          PA_LOW:  pin_q <= 1'b0;
          PA_HIGH: pin_q <= 1'b1;
          default: pin_q <= ~pin_q;
        endcase
      end else if (wr_pin) begin
        pin_q <= bus_wdata[0];
      end

      if (pulse_fire) sticky_q <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (wdt_reg_e'(bus_word))
      RG_IRQ:   rd_mux = DW'(irq_q);
      RG_CTRL:  rd_mux = DW'({ctrl_frz, ctrl_clr, ctrl_en});
      RG_COUNT: rd_mux = cnt;
      RG_MCFG:  rd_mux = DW'({mc_rext, mc_rint, mc_stop, 1'b0, mc_irq});
      RG_MATCH: rd_mux = match_q;
      RG_PIN:   rd_mux = DW'({pmode, 3'b000, pin_q});
      RG_PLEN:  rd_mux = DW'(plen_q);
      default:  rd_mux = DW'(sticky_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign wdt_irq   = irq_q;
  assign match_out = pin_q;
endmodule

// File: rtl/wdt_match_chk.sv
module wdt_match_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          sysrst_int,
  input logic          sysrst_ext,
  input logic          wdt_irq,
  input logic          sticky,
  input logic          evt,
  input logic          irq_en,
  input logic          stop_en,
  input logic          clr_req,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] match_val
);
  // R5: an enabled match event leaves the interrupt flag set
  a_r5_event_sets_irq: assert property (@(posedge clk) disable iff (rst)
    evt && irq_en |=> wdt_irq);

  // R6: stop-on-match freezes the count at the compare value
  a_r6_stop_holds: assert property (@(posedge clk) disable iff (rst)
    stop_en && (cnt == match_val) && !clr_req |=> $stable(cnt));

  // R8: the external reset never appears without the internal one
  a_r8_ext_within_int: assert property (@(posedge clk) disable iff (rst)
    sysrst_ext |-> sysrst_int);

  // R8: a pulse is never a single cycle long
  a_r8_min_width: assert property (@(posedge clk) disable iff (rst)
    $rose(sysrst_int) |=> sysrst_int);

  // R10: the status flag is sticky
  a_r10_sticky_keeps: assert property (@(posedge clk) disable iff (rst)
    sticky |=> sticky);

  // R10: any running pulse has been recorded
  a_r10_pulse_recorded: assert property (@(posedge clk) disable iff (rst)
    sysrst_int |-> sticky);
endmodule

bind wdog_match_timer wdt_match_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sysrst_int(sysrst_int), .sysrst_ext(sysrst_ext),
  .wdt_irq(wdt_irq), .sticky(sticky_q), .evt(match_evt), .irq_en(mc_irq),
  .stop_en(mc_stop), .clr_req(ctrl_clr), .cnt(cnt), .match_val(match_q)
);

// File: tb/wdog_match_timer_test.sv
`timescale 1ns/1ps
module wdog_match_timer_test;
  logic        clk = 1'b0, rst = 1'b1, dbg_halt = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        wdt_irq, match_out, sysrst_int, sysrst_ext;

  int n_chk = 0, n_bad = 0;
  bit chk_on = 0;

  always #10 clk = ~clk;

  wdog_match_timer uut (
    .clk(clk), .rst(rst), .dbg_halt(dbg_halt), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_irq(wdt_irq), .match_out(match_out), .sysrst_int(sysrst_int),
    .sysrst_ext(sysrst_ext)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, stepped on every rising edge
  bit m_en, m_clr, m_frz, m_irq, m_stop, m_rint, m_rext, m_seen, m_int, m_pout, m_pext, m_sticky;
  longint m_cnt, m_match, m_plen, m_pc;
  int m_tmr, m_mode;
  logic [31:0] m_rd;

  function automatic logic [31:0] mread(input int w);
    case (w)
      0: return 32'(m_int);
      1: return 32'({m_frz, m_clr, m_en});
      2: return 32'(m_cnt);
      3: return 32'({m_rext, m_rint, m_stop, 1'b0, m_irq});
      4: return 32'(m_match);
      5: return 32'((m_mode << 4) | m_pout);
      6: return 32'(m_plen);
      default: return 32'(m_sticky);
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_en, m_clr, m_frz, m_irq, m_stop, m_rint, m_rext} = '0;
      {m_seen, m_int, m_pout, m_pext, m_sticky} = '0;
      m_cnt = 0; m_match = 0; m_plen = 0; m_pc = 0; m_tmr = 0; m_mode = 0; m_rd = '0;
    end else begin
      bit hit, act, evt, cfire, run, f5, f6, req;
      longint ncnt;
      hit   = (m_cnt == m_match);
      act   = m_en && !m_clr && !(m_frz && dbg_halt);
      evt   = act && hit && !m_seen;
      cfire = m_clr && (m_tmr == 2);
      run   = act && !(m_stop && hit);
      f5    = bus_wr && bus_word == 3 && bus_wdata[5];
      f6    = bus_wr && bus_word == 3 && bus_wdata[6];
      if (bus_rd) m_rd = mread(int'(bus_word));
      ncnt  = cfire ? 0 : (run ? ((m_cnt + 1) & 64'hFFFF_FFFF) : m_cnt);
      m_tmr = !m_clr ? 0 : (m_tmr < 3 ? m_tmr + 1 : m_tmr);
      m_seen = hit && (m_seen || evt);
      req = f5 || f6 || (evt && (m_rint || m_rext));
      if (req && m_pc == 0) begin
        m_pc = m_plen + 6; m_pext = (f5 || f6) ? f6 : m_rext; m_sticky = 1;
      end else if (m_pc != 0) m_pc--;
      if (evt && m_irq) m_int = 1;
      else if (bus_wr && bus_word == 0 && bus_wdata[0]) m_int = 0;
      if (evt && m_mode != 0) m_pout = (m_mode == 1) ? 0 : (m_mode == 2) ? 1 : !m_pout;
      else if (bus_wr && bus_word == 5) m_pout = bus_wdata[0];
      if (bus_wr) case (bus_word)
        1: {m_frz, m_clr, m_en} = bus_wdata[2:0];
        3: {m_rext, m_rint, m_stop, m_irq} = {bus_wdata[4], bus_wdata[3], bus_wdata[2], bus_wdata[0]};
        4: m_match = bus_wdata;
        5: m_mode = int'(bus_wdata[5:4]);
        6: m_plen = bus_wdata[15:0];
        default: ;
      endcase
      m_cnt = ncnt;
    end
  end

  always @(negedge clk) begin
    if (chk_on && !rst) begin
      chk(bus_rdata == m_rd, "R11 model rdata", bus_rdata, m_rd);
      chk(wdt_irq == m_int, "R5 model irq", wdt_irq, m_int);
      chk(match_out == m_pout, "R7 model match_out", match_out, m_pout);
      chk(sysrst_int == (m_pc != 0), "R8 model sysrst_int", sysrst_int, m_pc != 0);
      chk(sysrst_ext == (m_pc != 0 && m_pext), "R8 model sysrst_ext", sysrst_ext, m_pc != 0 && m_pext);
    end
  end

  // tasks start and end at a falling edge
  task automatic wr(input int w, input logic [31:0] d);
    bus_wr = 1; bus_word = 3'(w); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int w, output logic [31:0] d);
    bus_rd = 1; bus_word = 3'(w);
    @(negedge clk);
    bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 100 && !sysrst_int; i++) @(negedge clk);
  endtask

  task automatic measure(output int n, output int ne);
    n = 0; ne = 0;
    while (sysrst_int && n < 1000) begin
      n++; if (sysrst_ext) ne++;
      @(negedge clk);
    end
  endtask

  task automatic clear_cnt();
    wr(1, 32'h2);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] a, b, c, d;
    int n, ne;
    repeat (3) @(negedge clk);
    rst = 0; chk_on = 1;
    // R1 reset state
    for (int w = 0; w < 8; w++) begin
      rd(w, a); chk(a == 0, "R1 reset register", a, 0);
    end
    chk({wdt_irq, match_out, sysrst_int, sysrst_ext} == 0, "R1 reset outputs",
        {wdt_irq, match_out, sysrst_int, sysrst_ext}, 0);

    // R5 interrupt on match, W1C, single firing
    wr(4, 20); wr(3, 1); wr(1, 1);
    repeat (30) @(negedge clk);
    chk(wdt_irq == 1, "R5 irq after match", wdt_irq, 1);
    wr(0, 1);
    chk(wdt_irq == 0, "R5 irq cleared", wdt_irq, 0);
    repeat (10) @(negedge clk);
    chk(wdt_irq == 0, "R5 fires once per match", wdt_irq, 0);

    // R5 clear colliding with a match event: set wins
    clear_cnt();
    wr(4, 12); wr(0, 1); wr(1, 1);
    repeat (12) @(negedge clk);
    wr(0, 1);
    chk(wdt_irq == 1, "R5 set wins over clear", wdt_irq, 1);
    wr(0, 1);

    // R6 stop on match
    clear_cnt();
    wr(3, 5); wr(4, 30); wr(1, 1);
    repeat (40) @(negedge clk);
    rd(2, a); chk(a == 30, "R6 counter stopped at match", a, 30);

    // R4 debug freeze
    clear_cnt();
    wr(3, 0); wr(4, 1000); wr(1, 5);
    repeat (5) @(negedge clk);
    dbg_halt = 1;
    rd(2, b); repeat (5) @(negedge clk); rd(2, c);
    chk(b == c, "R4 frozen while halted", c, b);
    dbg_halt = 0;
    repeat (3) @(negedge clk); rd(2, d);
    chk(d > c, "R4 resumes after halt", d, c);
    wr(1, 1); dbg_halt = 1;
    rd(2, b); repeat (4) @(negedge clk); rd(2, c);
    chk(c > b, "R4 halt ignored without freeze bit", c, b);
    dbg_halt = 0;

    // R2 stop by writing zero; R11 counter write ignored
    wr(1, 0);
    rd(2, a); repeat (4) @(negedge clk); rd(2, b);
    chk(a == b, "R2 counter stopped", b, a);
    wr(2, 55); rd(2, c);
    chk(c == b, "R11 counter write ignored", c, b);

    // R3 delayed clear
    wr(1, 2); rd(2, a);
    chk(a == b, "R3 old value right after request", a, b);
    repeat (2) @(negedge clk); rd(2, a);
    chk(a == 0, "R3 counter cleared", a, 0);

    // R7 pin actions
    wr(4, 8); wr(5, 32'h20); wr(1, 1);
    repeat (15) @(negedge clk);
    chk(match_out == 1, "R7 drive high on match", match_out, 1);
    clear_cnt(); wr(5, 32'h31); wr(1, 1);
    repeat (15) @(negedge clk);
    chk(match_out == 0, "R7 toggle on match", match_out, 0);
    clear_cnt(); wr(5, 32'h11); wr(1, 1);
    repeat (15) @(negedge clk);
    chk(match_out == 0, "R7 drive low on match", match_out, 0);
    rd(5, a); chk(a == 32'h10, "R7 pin register readback", a, 32'h10);

    // R8 internal pulse on match
    clear_cnt(); wr(6, 10); wr(3, 32'h08); wr(4, 5); wr(1, 1);
    wait_rise(); measure(n, ne);
    chk(n == 16, "R8 internal pulse width", n, 16);
    chk(ne == 0, "R8 internal-only pulse", ne, 0);
    rd(7, a); chk(a == 1, "R10 status set", a, 1);

    // R8 internal plus external pulse
    clear_cnt(); wr(3, 32'h10); wr(1, 1);
    wait_rise(); measure(n, ne);
    chk(n == 16 && ne == 16, "R8 external pulse width", ne, 16);

    // R9 force, with a second force during the pulse
    wr(1, 0);
    bus_wr = 1; bus_word = 3; bus_wdata = 32'h20;
    @(negedge clk);
    bus_wdata = 32'h40;
    @(negedge clk);
    bus_wr = 0;
    measure(n, ne);
    chk(n + 1 == 16, "R9 forced pulse not restarted", n + 1, 16);
    chk(ne == 0, "R9 second force ignored", ne, 0);
    rd(3, a); chk(a == 0, "R9 force bits read zero", a, 0);
    wr(3, 32'h40); measure(n, ne);
    chk(ne == 16, "R9 forced external pulse", ne, 16);

    // R10 sticky flag
    wr(7, 0); rd(7, a);
    chk(a == 1, "R10 write does not clear status", a, 1);
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    rd(7, a); chk(a == 0, "R10 cleared by power-on reset", a, 0);
    rd(6, a); chk(a == 0, "R1 pulse length after reset", a, 0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule